// File: doc/BRIEF.md
# Block Cipher Data Port Stager

This block is the data-side register front end of a block cipher accelerator. Software streams one 128-bit block into a single input register as four consecutive 32-bit writes. Each word passes through a selectable reordering (none, half-word swap, byte swap or full bit reversal) before being staged. The fourth accepted word launches a computation in an internal core. When the core finishes, the 128-bit result is latched and handed back as four consecutive 32-bit reads from a single output register, with the same reordering applied on the way out.

The cipher itself is replaced by a fixed-latency stub that XORs the block with a constant mask. Around it sit the control, status, interrupt-enable, interrupt-status and interrupt-clear registers. Completion is a sticky flag cleared only through the clear register. Writes and reads issued in the wrong order are rejected and recorded as error flags instead of corrupting the stream. A level interrupt is raised from the enabled status bits.

Top module: `cipher_port_stager`

## Requirements
- R1: Four accepted writes to the data-in register (word address 2) form one block: the first word becomes bits 127:96 and the fourth becomes bits 31:0. The fourth write starts the core, so status busy reads 1 on the next access.
- R2: After completion, four reads of the data-out register (word address 3) return the result words in order, bits 127:96 first. The stub result is the staged block XOR the CORE_MASK parameter.
- R3: Control register (word address 0) bits 1:0 select the word reordering. Code 0 is unchanged, code 1 swaps the 16-bit halves, code 2 reverses the byte order and code 3 reverses all 32 bits. The selected reordering is applied to every written data word and to every read result word.
- R4: Status register (word address 1) layout: bit 0 completion, bit 1 read error, bit 2 write error, bit 3 busy, bit 7 mirrors the key_valid_i input; all other bits read 0.
- R5: The completion flag sets when the core finishes and stays set, even after all result words are read, until a 1 is written to bit 0 of the interrupt clear register (word address 6).
- R6: A data-in write issued while the core is busy, or while result words remain unread, sets the write error flag and the word is discarded: the block being computed or read out is unchanged.
- R7: A data-out read issued while the completion flag is clear, or when no unread result word remains, returns 0 and sets the read error flag.
- R8: The core holds busy for exactly LATENCY cycles per block. With LATENCY cycles left idle after the fourth write, status still shows busy set and completion clear. Completion is visible within a few further accesses.
- R9: Interrupt status (word address 5): bit 0 completion, bit 1 read-or-write error, bit 2 key fault, bit 3 random-source fault. Fault bits set on a one-cycle pulse of key_fault_i or rng_fault_i and stay set. Writing 1 to bit k of the clear register clears status bit k; bit 1 clears both error flags.
- R10: The interrupt enable register (word address 4) uses the interrupt status layout, and irq is the OR of the status bits whose enable bit is 1.
- R11: After reset, control, status (with key_valid_i low), interrupt enable and interrupt status read 0 and irq is low.
- R12: A read request returns its data on bus_rdata one clock after the cycle in which it is presented; reads of the data-in and clear registers return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| key_valid_i | input | 1 | Key availability level, mirrored in status |
| key_fault_i | input | 1 | Key fault event pulse |
| rng_fault_i | input | 1 | Random-source fault event pulse |
| irq | output | 1 | Masked interrupt level |

## Verification
On every cycle, the assertions check the following:
- Rejected writes and reads land in their error flags.
- A premature read returns zero.
- The completion flag stays set until it is cleared and is raised after each core finish.
- The core's busy window never exceeds the configured latency.
- The unread-word count stays in range.
- A fully masked interrupt never fires.

The bench scenarios cover the rest: data correctness through the XOR stub under each of the four reordering codes, the ordering of words, and the preservation of a block when a stray write is dropped mid-computation or mid-readout. They also cover the status and interrupt register layouts at the port.

// File: rtl/cps_pkg.sv
package cps_pkg;

    localparam int DATA_W    = 32;
    localparam int BLK_WORDS = 4;
    localparam int BLK_W     = DATA_W * BLK_WORDS;
    localparam int ADDR_W    = 3;
    localparam int IRQ_W     = 4;

    typedef enum logic [1:0] {
        SWAP_NONE = 2'd0,
        SWAP_HALF = 2'd1,
        SWAP_BYTE = 2'd2,
        SWAP_BITS = 2'd3
    } swap_e;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] A_DIN  = 3'd2;
    localparam logic [ADDR_W-1:0] A_DOUT = 3'd3;
    localparam logic [ADDR_W-1:0] A_IEN  = 3'd4;
    localparam logic [ADDR_W-1:0] A_IST  = 3'd5;
    localparam logic [ADDR_W-1:0] A_ICLR = 3'd6;

    localparam int IB_DONE = 0;
    localparam int IB_RWE  = 1;
    localparam int IB_KEY  = 2;
    localparam int IB_RNG  = 3;

    typedef struct packed {
        logic done;
        logic rd_err;
        logic wr_err;
        logic key_err;
        logic rng_err;
    } flags_t;

    function automatic logic [DATA_W-1:0] swap_word(input logic [DATA_W-1:0] w,
                                                    input swap_e m);
        logic [DATA_W-1:0] r;
        case (m)
            SWAP_HALF: r = {w[15:0], w[31:16]};
            SWAP_BYTE: r = {w[7:0], w[15:8], w[23:16], w[31:24]};
            SWAP_BITS: for (int i = 0; i < DATA_W; i++) r[i] = w[DATA_W-1-i];
            default:   r = w;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cps_in_stager.sv
module cps_in_stager
    import cps_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [DATA_W-1:0] word,
    output logic             start,
    output logic [BLK_W-1:0] block
);
    localparam int CW = $clog2(BLK_WORDS);
    localparam logic [CW-1:0] LAST = CW'(BLK_WORDS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            start <= 1'b0;
            block <= '0;
        end else begin
            start <= 1'b0;
            if (push) begin
                block <= {block[BLK_W-DATA_W-1:0], word};
                if (cnt == LAST) begin
                    cnt   <= '0;
                    start <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cps_core_stub.sv
module cps_core_stub
    import cps_pkg::*;
#(
    parameter int               LATENCY   = 10,
    parameter logic [BLK_W-1:0] CORE_MASK = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [BLK_W-1:0] blk_in,
    output logic             busy,
    output logic             done,
    output logic [BLK_W-1:0] result
);
    localparam int CNTW = $clog2(LATENCY + 1);

    logic [CNTW-1:0]  cnt;
    logic [BLK_W-1:0] held;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            cnt    <= '0;
            held   <= '0;
            result <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy <= 1'b1;
                cnt  <= CNTW'(LATENCY);
                held <= blk_in;
            end else if (busy) begin
                if (cnt == CNTW'(1)) begin
                    busy   <= 1'b0;
                    done   <= 1'b1;
                    result <= held ^ CORE_MASK;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cps_out_buffer.sv
module cps_out_buffer
    import cps_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BLK_W-1:0]  result,
    input  logic              take,
    output logic [DATA_W-1:0] head,
    output logic [$clog2(BLK_WORDS+1)-1:0] remain
);
    localparam int RW = $clog2(BLK_WORDS + 1);
    localparam int IW = $clog2(BLK_WORDS);

    logic [DATA_W-1:0] words_q [BLK_WORDS];
    logic [IW-1:0]     idx;

    for (genvar g = 0; g < BLK_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)       words_q[g] <= '0;
            else if (load) words_q[g] <= result[BLK_W-1-g*DATA_W -: DATA_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx    <= '0;
            remain <= '0;
        end else if (load) begin
            idx    <= '0;
            remain <= RW'(BLK_WORDS);
        end else if (take && remain != '0) begin
            idx    <= idx + 1'b1;
            remain <= remain - 1'b1;
        end
    end

    assign head = words_q[idx];
endmodule

// File: rtl/cps_flags.sv
module cps_flags
    import cps_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             set_done,
    input  logic             set_rd_err,
    input  logic             set_wr_err,
    input  logic             set_key_err,
    input  logic             set_rng_err,
    input  logic             clr_we,
    input  logic [IRQ_W-1:0] clr_bits,
    input  logic             ien_we,
    input  logic [IRQ_W-1:0] ien_data,
    output flags_t           flags,
    output logic [IRQ_W-1:0] ien,
    output logic [IRQ_W-1:0] ist,
    output logic             irq
);
    logic [IRQ_W-1:0] clr;
    assign clr = clr_we ? clr_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            ien   <= '0;
        end else begin
            if (ien_we) ien <= ien_data;
            if (set_done)          flags.done <= 1'b1;
            else if (clr[IB_DONE]) flags.done <= 1'b0;
            if (set_rd_err)        flags.rd_err <= 1'b1;
            else if (clr[IB_RWE])  flags.rd_err <= 1'b0;
            if (set_wr_err)        flags.wr_err <= 1'b1;
            else if (clr[IB_RWE])  flags.wr_err <= 1'b0;
            if (set_key_err)       flags.key_err <= 1'b1;
            else if (clr[IB_KEY])  flags.key_err <= 1'b0;
            if (set_rng_err)       flags.rng_err <= 1'b1;
            else if (clr[IB_RNG])  flags.rng_err <= 1'b0;
        end
    end

    always_comb begin
        ist          = '0;
        ist[IB_DONE] = flags.done;
        ist[IB_RWE]  = flags.rd_err | flags.wr_err;
        ist[IB_KEY]  = flags.key_err;
        ist[IB_RNG]  = flags.rng_err;
    end

    assign irq = |(ist & ien);
endmodule

// File: rtl/cipher_port_stager.sv
module cipher_port_stager
    import cps_pkg::*;
#(
    parameter int               LATENCY   = 10,
    parameter logic [BLK_W-1:0] CORE_MASK = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              key_valid_i,
    input  logic              key_fault_i,
    input  logic              rng_fault_i,
    output logic              irq
);
    localparam int RW = $clog2(BLK_WORDS + 1);

    logic wr_req, rd_req;
    logic din_wr, dout_rd, din_block, din_accept, dout_ok;
    logic icr_clr_cc;
    swap_e mode_q;

    logic             stage_start, core_busy, core_done, busy_any;
    logic [BLK_W-1:0] stage_blk, core_res;
    logic [DATA_W-1:0] head_word;
    logic [RW-1:0]    remain;
    flags_t           flags;
    logic [IRQ_W-1:0] ien_q, ist_w;
    logic             st_ccf, st_rderr, st_wrerr;

    assign wr_req  = bus_sel &  bus_we;
    assign rd_req  = bus_sel & ~bus_we;
    assign din_wr  = wr_req && (bus_addr == A_DIN);
    assign dout_rd = rd_req && (bus_addr == A_DOUT);

    assign busy_any   = stage_start | core_busy;
    assign din_block  = busy_any | (remain != '0);
    assign din_accept = din_wr & ~din_block;
    assign dout_ok    = flags.done & (remain != '0);
    assign icr_clr_cc = wr_req && (bus_addr == A_ICLR) && bus_wdata[IB_DONE];

    assign st_ccf   = flags.done;
    assign st_rderr = flags.rd_err;
    assign st_wrerr = flags.wr_err;

    always_ff @(posedge clk) begin
        if (rst)                              mode_q <= SWAP_NONE;
        else if (wr_req && bus_addr == A_CTRL) mode_q <= swap_e'(bus_wdata[1:0]);
    end

    cps_in_stager u_stage (
        .clk   (clk),
        .rst   (rst),
        .push  (din_accept),
        .word  (swap_word(bus_wdata, mode_q)),
        .start (stage_start),
        .block (stage_blk)
    );

    cps_core_stub #(.LATENCY(LATENCY), .CORE_MASK(CORE_MASK)) u_core (
        .clk    (clk),
        .rst    (rst),
        .start  (stage_start),
        .blk_in (stage_blk),
        .busy   (core_busy),
        .done   (core_done),
        .result (core_res)
    );

    cps_out_buffer u_out (
        .clk    (clk),
        .rst    (rst),
        .load   (core_done),
        .result (core_res),
        .take   (dout_rd & dout_ok),
        .head   (head_word),
        .remain (remain)
    );

    cps_flags u_flags (
        .clk         (clk),
        .rst         (rst),
        .set_done    (core_done),
        .set_rd_err  (dout_rd & ~dout_ok),
        .set_wr_err  (din_wr & din_block),
        .set_key_err (key_fault_i),
        .set_rng_err (rng_fault_i),
        .clr_we      (wr_req && (bus_addr == A_ICLR)),
        .clr_bits    (bus_wdata[IRQ_W-1:0]),
        .ien_we      (wr_req && (bus_addr == A_IEN)),
        .ien_data    (bus_wdata[IRQ_W-1:0]),
        .flags       (flags),
        .ien         (ien_q),
        .ist         (ist_w),
        .irq         (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (rd_req) begin
            case (bus_addr)
                A_CTRL: bus_rdata <= {30'd0, mode_q};
                A_STAT: bus_rdata <= {24'd0, key_valid_i, 3'd0, busy_any,
                                      flags.wr_err, flags.rd_err, flags.done};
                A_DOUT: bus_rdata <= dout_ok ? swap_word(head_word, mode_q) : '0;
                A_IEN:  bus_rdata <= {28'd0, ien_q};
                A_IST:  bus_rdata <= {28'd0, ist_w};
                default: bus_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/cps_checker.sv
module cps_checker
    import cps_pkg::*;
#(
    parameter int LATENCY = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              din_wr,
    input logic              busy_any,
    input logic [$clog2(BLK_WORDS+1)-1:0] remain,
    input logic              st_wrerr,
    input logic              dout_rd,
    input logic              st_ccf,
    input logic              st_rderr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              icr_clr_cc,
    input logic              core_done,
    input logic              core_busy,
    input logic              irq,
    input logic [IRQ_W-1:0]  ien_q
);
    localparam int BW = $clog2(LATENCY + 2);
    logic [BW-1:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst)            busy_run <= '0;
        else if (core_busy) busy_run <= busy_run + 1'b1;
        else                busy_run <= '0;
    end

    assert_drop_write_R6: assert property (@(posedge clk) disable iff (rst)
        (din_wr && (busy_any || remain != '0)) |=> st_wrerr);

    assert_early_read_R7: assert property (@(posedge clk) disable iff (rst)
        (dout_rd && !st_ccf) |=> (bus_rdata == '0 && st_rderr));

    assert_done_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (st_ccf && !icr_clr_cc) |=> st_ccf);

    assert_done_raises_R5: assert property (@(posedge clk) disable iff (rst)
        core_done |=> st_ccf);

    assert_busy_window_R8: assert property (@(posedge clk) disable iff (rst)
        core_busy |-> (busy_run < BW'(LATENCY)));

    assert_remain_bound_R2: assert property (@(posedge clk) disable iff (rst)
        remain <= ($clog2(BLK_WORDS+1))'(BLK_WORDS));

    assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (ien_q == '0) |-> !irq);
endmodule

bind cipher_port_stager cps_checker #(.LATENCY(LATENCY)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .din_wr     (din_wr),
    .busy_any   (busy_any),
    .remain     (remain),
    .st_wrerr   (st_wrerr),
    .dout_rd    (dout_rd),
    .st_ccf     (st_ccf),
    .st_rderr   (st_rderr),
    .bus_rdata  (bus_rdata),
    .icr_clr_cc (icr_clr_cc),
    .core_done  (core_done),
    .core_busy  (core_busy),
    .irq        (irq),
    .ien_q      (ien_q)
);

// File: tb/sim_cipher_port_stager.sv
module sim_cipher_port_stager;
    localparam int CLK_PERIOD = 10;
    localparam int LAT = 10;
    localparam logic [127:0] MASK_TB = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        key_valid_i = 1'b0, key_fault_i = 1'b0, rng_fault_i = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    logic [31:0] mon_word;
    event        dout_evt;

    always #(CLK_PERIOD/2) clk = ~clk;

    cipher_port_stager #(.LATENCY(LAT), .CORE_MASK(MASK_TB)) u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .key_valid_i(key_valid_i), .key_fault_i(key_fault_i),
        .rng_fault_i(rng_fault_i), .irq(irq)
    );

    function automatic logic [31:0] ref_swap(input logic [31:0] w, input int m);
        logic [31:0] r = w;
        if (m == 1) r = (w << 16) | (w >> 16);
        else if (m == 2) for (int k = 0; k < 4; k++) r[8*k +: 8] = w[8*(3-k) +: 8];
        else if (m == 3) for (int k = 0; k < 32; k++) r[k] = w[31-k];
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic expect_reg(input logic [2:0] a, input logic [31:0] e, input string req);
        logic [31:0] d;
        bus_read(a, d);
        check(d === e, req, d, e);
    endtask

    // driver: stage one block, pushing the expected result words
    task automatic send_block(input int m, input logic [31:0] blk[4]);
        bus_write(3'd0, 32'(m));
        for (int i = 0; i < 4; i++) begin
            exp_q.push_back(ref_swap(ref_swap(blk[i], m) ^ MASK_TB[127-32*i -: 32], m));
            bus_write(3'd2, blk[i]);
        end
    endtask

    task automatic wait_done(input string req);
        logic [31:0] d = '0;
        for (int n = 0; n < 3*LAT && d[0] !== 1'b1; n++) bus_read(3'd1, d);
        check(d[0] === 1'b1, req, d, 32'h1);
    endtask

    task automatic drain(input int n);
        for (int i = 0; i < n; i++) begin
            logic [31:0] d;
            bus_read(3'd3, d);
            mon_word = d;
            -> dout_evt;
            #1;
        end
    endtask

    // monitor: compare each returned result word with the scoreboard
    initial begin
        forever begin
            @(dout_evt);
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected word", mon_word, 32'h0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check(mon_word === e, "R2/R3 result word", mon_word, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 32'h0, 32'h1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] blk[4];
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        expect_reg(3'd0, 32'h0, "R11 ctrl");
        expect_reg(3'd1, 32'h0, "R11 status");
        expect_reg(3'd4, 32'h0, "R11 ien");
        expect_reg(3'd5, 32'h0, "R11 ist");
        check(irq === 1'b0, "R11 irq", 32'(irq), 32'h0);

        // R4 key-valid mirror at bit 7
        key_valid_i = 1'b1;
        expect_reg(3'd1, 32'h80, "R4 key valid bit");
        key_valid_i = 1'b0;

        // R7 premature read returns zero, sets read error (status bit 1)
        bus_read(3'd3, d);
        check(d === 32'h0, "R7 early read data", d, 32'h0);
        expect_reg(3'd1, 32'h2, "R7 read error flag");
        expect_reg(3'd5, 32'h2, "R9 ist rw error");
        bus_write(3'd6, 32'h2);
        expect_reg(3'd1, 32'h0, "R9 clear rw error");

        // R1 R2 R8 plain block with latency observation
        blk = '{32'h00112233, 32'h44556677, 32'h8899AABB, 32'hCCDDEEFF};
        send_block(0, blk);
        repeat (LAT - 1) @(negedge clk);
        expect_reg(3'd1, 32'h8, "R8 busy held, done clear");
        wait_done("R8 done within window");
        drain(4);
        expect_reg(3'd1, 32'h1, "R5 done stays after reads");
        bus_read(3'd3, d);
        check(d === 32'h0, "R7 read past end", d, 32'h0);
        expect_reg(3'd1, 32'h3, "R7 read error after drain");
        bus_write(3'd6, 32'h3);
        expect_reg(3'd1, 32'h0, "R5 done cleared by clear reg");

        // R3 each reordering code
        for (int m = 1; m < 4; m++) begin
            blk = '{32'h12345678 + 32'(m), 32'hA5C3F00F, 32'h80000001, 32'h0F0FF0F0 ^ 32'(m)};
            send_block(m, blk);
            expect_reg(3'd1, 32'h8, "R1 busy after fourth write");
            wait_done("R3 done");
            drain(4);
            bus_write(3'd6, 32'h1);
        end
        expect_reg(3'd0, 32'h3, "R3 ctrl readback");

        // R6 stray write while busy is dropped
        blk = '{32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF, 32'hFEDCBA98};
        send_block(2, blk);
        bus_write(3'd2, 32'h55555555);
        expect_reg(3'd1, 32'hC, "R6 write error while busy");
        wait_done("R6 done");
        drain(4);
        bus_write(3'd6, 32'h3);

        // R6 stray write while result words unread
        blk = '{32'h11111111, 32'h22222222, 32'h33333333, 32'h44444444};
        send_block(0, blk);
        wait_done("R6 done 2");
        drain(2);
        bus_write(3'd2, 32'h99999999);
        expect_reg(3'd1, 32'h5, "R6 write error with unread words");
        drain(2);
        bus_write(3'd6, 32'h3);
        check(exp_q.size() == 0, "R2 scoreboard empty", 32'(exp_q.size()), 32'h0);

        // R9 R10 interrupt masking
        blk = '{32'h0, 32'h0, 32'h0, 32'h1};
        send_block(0, blk);
        wait_done("R10 done");
        check(irq === 1'b0, "R10 irq masked", 32'(irq), 32'h0);
        bus_write(3'd4, 32'h1);
        check(irq === 1'b1, "R10 irq enabled", 32'(irq), 32'h1);
        expect_reg(3'd5, 32'h1, "R9 ist done");
        drain(4);
        bus_write(3'd6, 32'h1);
        check(irq === 1'b0, "R10 irq after clear", 32'(irq), 32'h0);
        key_fault_i = 1'b1; @(negedge clk); key_fault_i = 1'b0;
        expect_reg(3'd5, 32'h4, "R9 key fault sticky");
        check(irq === 1'b0, "R10 key fault masked", 32'(irq), 32'h0);
        bus_write(3'd4, 32'h4);
        check(irq === 1'b1, "R10 key fault enabled", 32'(irq), 32'h1);
        rng_fault_i = 1'b1; @(negedge clk); rng_fault_i = 1'b0;
        expect_reg(3'd5, 32'hC, "R9 rng fault sticky");
        bus_write(3'd6, 32'hC);
        expect_reg(3'd5, 32'h0, "R9 faults cleared");
        check(irq === 1'b0, "R10 irq low", 32'(irq), 32'h0);
        expect_reg(3'd2, 32'h0, "R12 data-in reads zero");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule